// File: doc/BRIEF.md
# I2S Master Audio Port

This block is the serial audio port of a USB audio bridge, and it is always the clock master. Its clock input is the master clock, which runs at 256 times the sample rate: 12.288 MHz for 48 kHz, or 11.2896 MHz for 44.1 kHz. The clock is passed on to the attached converters outside this block. The block divides that clock into a bit clock and a left/right word clock. Attached devices act as slaves. One word-clock period spans 64 bit clocks, so each channel has a slot of 32 bit clocks.

On playback, a stereo pair of 16-bit samples is shifted out MSB first. The left sample goes in the first slot and the right sample in the second. Each sample fills the top 16 bits of its slot, and the rest of the slot is zero. The active pair is also driven on a parallel converter output, which changes at the start of the same frame. At the start of each frame the block asks for the next pair with a one-cycle request. A pair offered at any time during a frame goes on air in the following frame. If no pair is offered, the current pair is sent again.

On record, the serial input is sampled on each rising bit-clock edge, and only the left slot is kept, as a mono sample. A select input chooses the record source: the captured serial word, or a parallel sample from an internal ADC. In both cases a one-cycle strobe marks the new record sample.

The frame timer is a four-state machine, and its state tells which part of the frame is on the line. The states are:
- `SL_LDATA`: left data, bits 0 to 15.
- `SL_LPAD`: left padding, bits 16 to 31.
- `SL_RDATA`: right data, bits 32 to 47.
- `SL_RPAD`: right padding, bits 48 to 63.

The state steps through LDATA→LPAD→RDATA→RPAD and then wraps back to LDATA at the frame boundary. Each step happens when the phase counter reaches the first clock of the next part.

Top module: `i2s_master_port`

## Requirements
- R1: After reset, `bclk`, `lrclk`, `sdout`, `play_req` and `rec_valid` are 0, and `dac_left`, `dac_right` and `rec_sample` are 0.
- R2: `bclk` has a period of 4 clocks. Counting clocks from the start of the frame, it is low on clocks 0 and 1 of each group of 4 and high on clocks 2 and 3.
- R3: `lrclk` has a period of 256 clocks. It is high from bit 31 through bit 62 of the frame and low for the rest of the frame. Bit n spans clocks 4n to 4n+3 from the start of the frame.
- R4: `sdout` carries the left sample MSB first in bits 0 to 15, so the MSB starts one bit clock after `lrclk` falls. Bits 16 to 31 are 0.
- R5: `sdout` carries the right sample MSB first in bits 32 to 47, and bits 48 to 63 are 0. `sdout` only changes when `bclk` falls.
- R6: `play_req` is high for exactly clock 0 of each frame, except the frame that begins at reset. A pair offered with `play_valid` during one frame appears on `sdout` in the next frame. From clock 0 of that frame it is also on `dac_left`/`dac_right`.
- R7: When no pair is offered during a frame, the next frame sends the same pair again and `dac_left`/`dac_right` keep their values.
- R8: With `rec_sel`=0, `sdin` is sampled on the rising edge of `bclk` during bits 0 to 15. `rec_valid` pulses during clock 62 of the frame, and `rec_sample` then holds the left word, MSB first. Right-slot data on `sdin` leaves `rec_sample` unchanged.
- R9: With `rec_sel`=1, `rec_valid` pulses at the same clock, and `rec_sample` takes the value of `adc_sample`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256x the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| play_valid | input | 1 | Offers the next playback pair |
| play_left | input | 16 | Next left playback sample |
| play_right | input | 16 | Next right playback sample |
| play_req | output | 1 | One-clock request for the next pair, at frame start |
| dac_left | output | 16 | Left sample of the pair on air |
| dac_right | output | 16 | Right sample of the pair on air |
| bclk | output | 1 | Bit clock, clk/4 |
| lrclk | output | 1 | Word clock, clk/256, low for the left slot |
| sdout | output | 1 | Serial playback data |
| sdin | input | 1 | Serial record data |
| rec_sel | input | 1 | Record source: 0 serial input, 1 internal ADC |
| adc_sample | input | 16 | Parallel sample from the internal ADC |
| rec_sample | output | 16 | Mono record sample |
| rec_valid | output | 1 | One-clock strobe for a new record sample |

## Verification
The hardest point to reach is the handover at the frame boundary. A pair offered in the middle of one frame must be on air from the very first clock of the next frame, on both the serial line and the converter outputs. A frame with no offer must repeat the pair exactly. The stimulus runs whole frames in a row. It offers a different pair in the middle of some frames and no pair in others. Every serial bit is rebuilt and compared, together with the converter outputs at clock 0 and clock 1. The record side drives different left and right words in the same frames, so a capture that took in right-slot bits would change the stored word, and this is checked at the last clock of the frame.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
    typedef enum logic [1:0] {
        SL_LDATA,
        SL_LPAD,
        SL_RDATA,
        SL_RPAD
    } slot_e;
endpackage

// File: rtl/i2s_frame_timer.sv
module i2s_frame_timer
    import i2s_port_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32,
    parameter int BCLK_DIV = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic                        bclk_q,
    output logic                        lrclk_q,
    output slot_e                       st_n,
    output logic [$clog2(SAMPLE_W)-1:0] idx_n,
    output logic                        frame_wrap,
    output logic                        rx_strobe,
    output logic                        rx_last
);
    localparam int DIV_W  = $clog2(BCLK_DIV);
    localparam int BIT_W  = $clog2(2 * SLOT_W);
    localparam int CNT_W  = DIV_W + BIT_W;
    localparam int IDX_W  = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] C_LPAD   = CNT_W'(SAMPLE_W * BCLK_DIV);
    localparam logic [CNT_W-1:0] C_RDATA  = CNT_W'(SLOT_W * BCLK_DIV);
    localparam logic [CNT_W-1:0] C_RPAD   = CNT_W'((SLOT_W + SAMPLE_W) * BCLK_DIV);
    localparam logic [DIV_W-1:0] PH_RISE  = DIV_W'(BCLK_DIV / 2);
    localparam logic [DIV_W-1:0] PH_SAMP  = DIV_W'(BCLK_DIV / 2 - 1);
    localparam logic [BIT_W-1:0] B_LR_HI  = BIT_W'(SLOT_W - 1);
    localparam logic [BIT_W-1:0] B_LR_LO  = BIT_W'(2 * SLOT_W - 2);
    localparam logic [BIT_W-1:0] B_LAST   = BIT_W'(SAMPLE_W - 1);

    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [DIV_W-1:0] phase_q, phase_n;
    logic [BIT_W-1:0] bit_q, bit_n;
    slot_e            st_q;

    assign cnt_n      = cnt_q + 1'b1;
    assign phase_q    = cnt_q[DIV_W-1:0];
    assign bit_q      = cnt_q[CNT_W-1:DIV_W];
    assign phase_n    = cnt_n[DIV_W-1:0];
    assign bit_n      = cnt_n[CNT_W-1:DIV_W];
    assign idx_n      = bit_n[IDX_W-1:0];
    assign frame_wrap = (cnt_q == CNT_MAX);
    assign rx_strobe  = (phase_q == PH_SAMP) && (st_q == SL_LDATA);
    assign rx_last    = rx_strobe && (bit_q == B_LAST);

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            SL_LDATA: if (cnt_n == C_LPAD)     st_n = SL_LPAD;
            SL_LPAD:  if (cnt_n == C_RDATA)    st_n = SL_RDATA;
            SL_RDATA: if (cnt_n == C_RPAD)     st_n = SL_RPAD;
            SL_RPAD:  if (cnt_n == '0)         st_n = SL_LDATA;
            default:                           st_n = SL_LDATA;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= SL_LDATA;
        else     st_q <= st_n;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            bclk_q  <= 1'b0;
            lrclk_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            bclk_q  <= (phase_n >= PH_RISE);
            lrclk_q <= (bit_n >= B_LR_HI) && (bit_n <= B_LR_LO);
        end
    end

    // R3: the word clock moves only on a falling bit-clock edge
    p_lrclk_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (lrclk_q != $past(lrclk_q)) |-> (!bclk_q && $past(bclk_q)));

    // R3: a new frame starts in the left slot, word clock low
    p_wrap_left_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SL_LDATA && $past(st_q) == SL_RPAD) |-> !lrclk_q);
endmodule

// File: rtl/i2s_play_path.sv
module i2s_play_path
    import i2s_port_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  slot_e                       st_n,
    input  logic [$clog2(SAMPLE_W)-1:0] idx_n,
    input  logic                        frame_wrap,
    input  logic                        bclk_q,
    input  logic                        play_valid,
    input  logic [SAMPLE_W-1:0]         play_left,
    input  logic [SAMPLE_W-1:0]         play_right,
    output logic                        play_req,
    output logic [SAMPLE_W-1:0]         dac_left,
    output logic [SAMPLE_W-1:0]         dac_right,
    output logic                        sdout
);
    logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r, nl, nr;
    logic                pend_v;
    logic                bit_n;

    always_comb begin
        nl = act_l;
        nr = act_r;
        if (frame_wrap) begin
            if (play_valid) begin
                nl = play_left;
                nr = play_right;
            end else if (pend_v) begin
                nl = pend_l;
                nr = pend_r;
            end
        end
    end

    always_comb begin
        bit_n = 1'b0;
        unique case (st_n)
            SL_LDATA: bit_n = nl[~idx_n];
            SL_RDATA: bit_n = nr[~idx_n];
            SL_LPAD, SL_RPAD: bit_n = 1'b0;
            default:  bit_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_l   <= '0;
            pend_r   <= '0;
            pend_v   <= 1'b0;
            act_l    <= '0;
            act_r    <= '0;
            sdout    <= 1'b0;
            play_req <= 1'b0;
        end else begin
            if (frame_wrap) begin
                pend_v <= 1'b0;
            end else if (play_valid) begin
                pend_l <= play_left;
                pend_r <= play_right;
                pend_v <= 1'b1;
            end
            act_l    <= nl;
            act_r    <= nr;
            sdout    <= bit_n;
            play_req <= frame_wrap;
        end
    end

    assign dac_left  = act_l;
    assign dac_right = act_r;

    // R5: serial data changes only as the bit clock falls
    p_sdout_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (sdout != $past(sdout)) |-> (!bclk_q && $past(bclk_q)));

    // R6: the request is a single-clock pulse
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        play_req |=> !play_req);

    // R6: the converter pair changes only at a frame start
    p_dac_at_frame_r6: assert property (@(posedge clk) disable iff (rst)
        (dac_left != $past(dac_left)) |-> play_req);
endmodule

// File: rtl/i2s_rec_path.sv
module i2s_rec_path #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_strobe,
    input  logic                rx_last,
    input  logic                lrclk_q,
    input  logic                sdin,
    input  logic                rec_sel,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic [SAMPLE_W-1:0] rec_sample,
    output logic                rec_valid
);
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] word;

    assign word = {shreg[SAMPLE_W-2:0], sdin};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            rec_sample <= '0;
            rec_valid  <= 1'b0;
        end else begin
            rec_valid <= 1'b0;
            if (rx_strobe) shreg <= word;
            if (rx_last) begin
                rec_sample <= rec_sel ? adc_sample : word;
                rec_valid  <= 1'b1;
            end
        end
    end

    // R8: strobe lasts one clock
    p_rec_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

    // R8: a record sample completes inside the left slot
    p_rec_left_r8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !lrclk_q);

    // R8: stored sample moves only with its strobe
    p_rec_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_sample != $past(rec_sample)) |-> rec_valid);
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
    import i2s_port_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32,
    parameter int BCLK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                play_valid,
    input  logic [SAMPLE_W-1:0] play_left,
    input  logic [SAMPLE_W-1:0] play_right,
    output logic                play_req,
    output logic [SAMPLE_W-1:0] dac_left,
    output logic [SAMPLE_W-1:0] dac_right,
    output logic                bclk,
    output logic                lrclk,
    output logic                sdout,
    input  logic                sdin,
    input  logic                rec_sel,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic [SAMPLE_W-1:0] rec_sample,
    output logic                rec_valid
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    slot_e            st_n;
    logic [IDX_W-1:0] idx_n;
    logic             frame_wrap, rx_strobe, rx_last;

    i2s_frame_timer #(
        .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .BCLK_DIV(BCLK_DIV)
    ) i_timer (
        .clk(clk), .rst(rst), .bclk_q(bclk), .lrclk_q(lrclk),
        .st_n(st_n), .idx_n(idx_n), .frame_wrap(frame_wrap),
        .rx_strobe(rx_strobe), .rx_last(rx_last)
    );

    i2s_play_path #(.SAMPLE_W(SAMPLE_W)) i_play (
        .clk(clk), .rst(rst), .st_n(st_n), .idx_n(idx_n),
        .frame_wrap(frame_wrap), .bclk_q(bclk),
        .play_valid(play_valid), .play_left(play_left),
        .play_right(play_right), .play_req(play_req),
        .dac_left(dac_left), .dac_right(dac_right), .sdout(sdout)
    );

    i2s_rec_path #(.SAMPLE_W(SAMPLE_W)) i_rec (
        .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_last(rx_last),
        .lrclk_q(lrclk), .sdin(sdin), .rec_sel(rec_sel),
        .adc_sample(adc_sample), .rec_sample(rec_sample),
        .rec_valid(rec_valid)
    );
endmodule

// File: tb/test_i2s_master_port.sv
module test_i2s_master_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        play_valid = 1'b0;
    logic [15:0] play_left = '0, play_right = '0;
    logic        play_req;
    logic [15:0] dac_left, dac_right;
    logic        bclk, lrclk, sdout;
    logic        sdin = 1'b0;
    logic        rec_sel = 1'b0;
    logic [15:0] adc_sample = '0;
    logic [15:0] rec_sample;
    logic        rec_valid;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] rec_hold = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_master_port i_i2s_master_port (
        .clk(clk), .rst(rst), .play_valid(play_valid), .play_left(play_left),
        .play_right(play_right), .play_req(play_req), .dac_left(dac_left),
        .dac_right(dac_right), .bclk(bclk), .lrclk(lrclk), .sdout(sdout),
        .sdin(sdin), .rec_sel(rec_sel), .adc_sample(adc_sample),
        .rec_sample(rec_sample), .rec_valid(rec_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one frame from clock 0, at the negedge where the frame begins.
    task automatic run_frame(
        input logic [15:0] exp_l, input logic [15:0] exp_r, input logic exp_req,
        input logic [15:0] in_l, input logic [15:0] in_r,
        input logic sel, input logic [15:0] adc,
        input logic offer, input logic [15:0] nxt_l, input logic [15:0] nxt_r);
        logic [63:0] got, want, sin;
        int bad_bclk, bad_lr, bad_rv;
        logic [15:0] rec_exp;
        got = '0; bad_bclk = 0; bad_lr = 0; bad_rv = 0;
        want = {exp_l, 16'h0, exp_r, 16'h0};
        sin  = {in_l, 16'h0, in_r, 16'h0};
        rec_exp = sel ? adc : in_l;
        rec_sel = sel;
        adc_sample = adc;
        for (int i = 0; i < 256; i++) begin
            int b;
            b = i / 4;
            if (bclk !== ((i % 4) >= 2)) bad_bclk++;
            if (lrclk !== (b >= 31 && b <= 62)) bad_lr++;
            if ((i % 4) == 2) got[63-b] = sdout;
            if ((i % 4) == 0) sdin = sin[63-b];
            if (i == 0) check("R6 play_req at clock 0", 64'(play_req), 64'(exp_req));
            if (i == 1) begin
                check("R6 play_req clears", 64'(play_req), 64'(0));
                check("R6/R7 dac pair at frame start", {32'h0, dac_left, dac_right},
                      {32'h0, exp_l, exp_r});
            end
            if (i == 62) begin
                check("R8/R9 rec_valid at clock 62", 64'(rec_valid), 64'(1));
                check("R8/R9 rec_sample", 64'(rec_sample), 64'(rec_exp));
            end else if (rec_valid !== 1'b0) bad_rv++;
            if (i == 255) check("R8 right slot ignored", 64'(rec_sample), 64'(rec_exp));
            play_valid = offer && (i == 100);
            play_left  = nxt_l;
            play_right = nxt_r;
            @(negedge clk);
        end
        play_valid = 1'b0;
        check("R2 bclk shape", 64'(bad_bclk), 64'(0));
        check("R3 lrclk shape", 64'(bad_lr), 64'(0));
        check("R8 rec_valid single pulse", 64'(bad_rv), 64'(0));
        check("R4/R5 serial frame", got, want);
        rec_hold = rec_exp;
    endtask

    task automatic t_reset;
        check("R1 reset outputs", {56'h0, bclk, lrclk, sdout, play_req, rec_valid, 3'b0}, 64'h0);
        check("R1 reset words", {16'h0, dac_left, dac_right, rec_sample}, 64'h0);
    endtask

    task automatic t_first_offer;
        run_frame(16'h0, 16'h0, 1'b0, 16'h8001, 16'h7FFE, 1'b0, 16'h0,
                  1'b1, 16'hA5C3, 16'h3C5A);
    endtask

    task automatic t_second_offer_capture;
        run_frame(16'hA5C3, 16'h3C5A, 1'b1, 16'h9E37, 16'hFFFF, 1'b0, 16'h0,
                  1'b1, 16'h1F2E, 16'hC0DE);
    endtask

    task automatic t_repeat_adc;
        run_frame(16'h1F2E, 16'hC0DE, 1'b1, 16'h0000, 16'hFFFF, 1'b1, 16'h1234,
                  1'b0, 16'h5555, 16'h5555);
        run_frame(16'h1F2E, 16'hC0DE, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 16'h4321,
                  1'b0, 16'h0, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_first_offer();
        t_second_offer_capture();
        t_repeat_adc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule